// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter Stage

This block is a small synchronous up-counter meant to be chained into wider counters. Every state bit changes on the rising clock edge. The counter advances only when two separate count-enable inputs are both high. An active-low load input presets the count from a parallel data word. An active-low clear input zeroes the count.

A combinational carry output signals that this stage is at its all-ones value while its carry-forward enable is high. That output drives the carry-forward enable of the next stage. All stages share the clock and the other enable, so a chain of stages behaves as one wide synchronous counter.

A build-time parameter selects how clear behaves. In one form it acts at once, with no clock. In the other it acts at the next rising edge. The clock-edge form allows a shortened count cycle: a decode of the desired last value is fed back into clear.

Top module: `bincnt_stage`

## Requirements
- R1: With clear and load inactive (high), the count advances by one at a rising edge exactly when `en_p` and `en_t` are both high, and it wraps from all ones (15 at the default width) to 0.
- R2: `rco` is high exactly when `en_t` is high and the count is all ones, whatever the level of `en_p`. It follows its inputs combinationally, with no clock delay.
- R3: When `load_n` is low at a rising edge and clear is inactive, the count takes the value of `din`, whatever the levels of `en_p` and `en_t`.
- R4: With clear and load inactive, the count keeps its value across a rising edge when `en_p` or `en_t` is low.
- R5: With `ASYNC_CLR` = 1, a low level on `clr_n` zeroes the count at once, between clock edges, and keeps it at zero across edges whatever the levels of `load_n`, `en_p` and `en_t`.
- R6: With `ASYNC_CLR` = 0, a low level on `clr_n` leaves the count unchanged until the next rising edge. At that edge the count becomes 0, overriding load and both enables.
- R7: Changes on `load_n`, `en_p`, `en_t` or `din` between clock edges leave the count unchanged until the next rising edge.
- R8: In the clock-edge clear form, driving `clr_n` low when the count equals 9 gives a repeating cycle 0, 1, ..., 9, 0.
- R9: Three 4-bit stages chain into one 12-bit counter. The chain shares `en_p` and the clock, feeds the first stage's `en_t` from outside, and drives each later stage's `en_t` from the previous stage's `rco`. It matches a 12-bit counter that advances when both outer enables are high, through a full wrap of all stages.
- R10: The sequence "clear, preset 12, count four times with both enables high" yields 0, 12, 13, 14, 15, 0. Two more counts give 1 and 2. The value then holds while either enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; acts at once or at the edge, set by `ASYNC_CLR` |
| load_n | input | 1 | Active-low synchronous parallel preset |
| en_p | input | 1 | Count enable; gates counting only |
| en_t | input | 1 | Count enable that also gates `rco` |
| din | input | WIDTH | Preset data |
| q | output | WIDTH | Current count |
| rco | output | 1 | Carry out: `en_t` high and `q` all ones |

## Verification
The hardest situations to reach from the ports are an immediate clear that lands between two edges, and a full carry-through of a three-stage chain.

- **Clear between edges.** The bench drops `clr_n` a few time units after a falling edge. It samples the count before the next rising edge, so it can see that the immediate-clear form has already gone to zero while the edge form has not. It holds clear low across that edge and releases it on a later falling edge.
- **Full carry-through.** The chain needs more than 4096 enabled cycles before the top stage wraps. The bench runs about 4800 cycles, with each outer enable dropped on its own periodic pattern. This makes every stage see its carry input rise and fall many times, mid-count.

// File: rtl/bincnt_pkg.sv
package bincnt_pkg;
  // Operation selected for the next rising edge (clear is handled in the register)
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_STEP   = 2'd1,
    OP_PRESET = 2'd2
  } op_e;
endpackage

// File: rtl/bincnt_ctrl.sv
module bincnt_ctrl (
  input  logic              load_n,
  input  logic              en_p,
  input  logic              en_t,
  output bincnt_pkg::op_e   op
);
  import bincnt_pkg::*;
  // Load beats counting; counting needs both enables
  always_comb begin
    if (!load_n)            op = OP_PRESET;
    else if (en_p && en_t)  op = OP_STEP;
    else                    op = OP_HOLD;
  end
endmodule

// File: rtl/bincnt_next.sv
module bincnt_next #(
  parameter int WIDTH = 4
) (
  input  bincnt_pkg::op_e    op,
  input  logic [WIDTH-1:0]   cur,
  input  logic [WIDTH-1:0]   din,
  output logic [WIDTH-1:0]   nxt
);
  import bincnt_pkg::*;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  always_comb begin
    unique case (op)
      OP_STEP:   nxt = cur + ONE;   // natural wrap at all ones
      OP_PRESET: nxt = din;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/bincnt_reg.sv
module bincnt_reg #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/bincnt_carry.sv
module bincnt_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_t,
  output logic             rco
);
  assign rco = en_t & (&q);
endmodule

// File: rtl/bincnt_stage.sv
module bincnt_stage #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  bincnt_pkg::op_e    op;
  logic [WIDTH-1:0]   nxt;

  bincnt_ctrl u_ctrl (
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .op     (op)
  );

  bincnt_next #(.WIDTH(WIDTH)) u_next (
    .op  (op),
    .cur (q),
    .din (din),
    .nxt (nxt)
  );

  bincnt_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .q     (q)
  );

  bincnt_carry #(.WIDTH(WIDTH)) u_carry (
    .q    (q),
    .en_t (en_t),
    .rco  (rco)
  );
endmodule

// File: rtl/bincnt_chk.sv
module bincnt_chk #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             rco
);
  // Becomes 1 once a clear has been seen at an edge; the count is known from then on
  logic settled = 1'b0;
  always_ff @(posedge clk) begin
    if (!clr_n) settled <= 1'b1;
  end

  p_count_r1: assert property (@(posedge clk) disable iff (!clr_n || !settled)
    (load_n && en_p && en_t) |=> (q == WIDTH'($past(q) + 1'b1)));

  p_carry_t_r2: assert property (@(posedge clk) disable iff (!settled)
    (!en_t) |-> (!rco));

  p_carry_q_r2: assert property (@(posedge clk) disable iff (!settled)
    (q != '1) |-> (!rco));

  p_load_r3: assert property (@(posedge clk) disable iff (!clr_n || !settled)
    (!load_n) |=> (q == $past(din)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n || !settled)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  generate
    if (ASYNC_CLR) begin : g_aclr
      p_aclr_r5: assert property (@(posedge clk) disable iff (!settled)
        (!clr_n) |-> (q == '0));
    end else begin : g_sclr
      p_sclr_r6: assert property (@(posedge clk) disable iff (!settled)
        (!clr_n) |=> (q == '0));
    end
  endgenerate
endmodule

bind bincnt_stage bincnt_chk #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .en_p   (en_p),
  .en_t   (en_t),
  .din    (din),
  .q      (q),
  .rco    (rco)
);

// File: tb/sim_bincnt_stage.sv
module sim_bincnt_stage;
  localparam int CLK_P = 10;
  localparam int W     = 4;
  localparam int NSTG  = 3;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;

  // Shared stimulus for the two single stages
  logic         load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic         ca_n = 1'b0, cs_n = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] qa, qs;
  logic         ra, rs;

  bincnt_stage #(.WIDTH(W), .ASYNC_CLR(1'b1)) u0 (
    .clk(clk), .clr_n(ca_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(qa), .rco(ra));

  bincnt_stage #(.WIDTH(W), .ASYNC_CLR(1'b0)) u1 (
    .clk(clk), .clr_n(cs_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(qs), .rco(rs));

  // Modulus-10 stage: clear fed back from a decode of 9
  logic         mod_go = 1'b0;
  logic [W-1:0] qm;
  logic         rm;
  logic         mclr_n;
  assign mclr_n = mod_go & (qm != 4'd9);

  bincnt_stage #(.WIDTH(W), .ASYNC_CLR(1'b0)) u2 (
    .clk(clk), .clr_n(mclr_n), .load_n(1'b1), .en_p(1'b1), .en_t(1'b1),
    .din('0), .q(qm), .rco(rm));

  // Cascade of three stages
  logic                cas_p = 1'b0, cas_t = 1'b0, cas_clr_n = 1'b0;
  logic [NSTG*W-1:0]   cqv;
  logic [NSTG-1:0]     cr, ct;
  assign ct[0] = cas_t;

  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_cas
      if (g > 0) begin : g_link
        assign ct[g] = cr[g-1];
      end
      bincnt_stage #(.WIDTH(W), .ASYNC_CLR(1'b0)) u_cas (
        .clk(clk), .clr_n(cas_clr_n), .load_n(1'b1), .en_p(cas_p), .en_t(ct[g]),
        .din('0), .q(cqv[g*W +: W]), .rco(cr[g]));
    end
  endgenerate

  int ma = 0, ms = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int nx(int cur, bit clr, bit ld, bit p, bit t, int d);
    if (!clr)      return 0;
    if (!ld)       return d;
    if (p && t)    return (cur + 1) % 16;
    return cur;
  endfunction

  task automatic cyc(input bit ld, input bit p, input bit t, input int d,
                     input bit ca, input bit cs, input string tag);
    @(negedge clk);
    load_n = ld; en_p = p; en_t = t; din = W'(d); ca_n = ca; cs_n = cs;
    ma = nx(ma, ca, ld, p, t, d);
    ms = nx(ms, cs, ld, p, t, d);
    @(posedge clk); #1;
    chk({tag, " qa"}, 32'(qa), 32'(ma));
    chk({tag, " qs"}, 32'(qs), 32'(ms));
    chk({tag, " R2 rco a"}, 32'(ra), 32'(t && ma == 15));
    chk({tag, " R2 rco s"}, 32'(rs), 32'(t && ms == 15));
  endtask

  initial begin
    int mm;
    int cw;
    // Reset state after clear at an edge (R5 R6)
    cyc(1, 0, 0, 0, 0, 0, "R5 R6 reset");
    // Reference sequence R10
    cyc(0, 0, 0, 12, 1, 1, "R10 preset12");
    for (int k = 0; k < 6; k++) cyc(1, 1, 1, 0, 1, 1, "R10 R1 count");
    cyc(1, 0, 1, 0, 1, 1, "R10 R4 inhibit p");
    cyc(1, 1, 0, 0, 1, 1, "R10 R4 inhibit t");
    // R2: carry independent of P
    cyc(0, 0, 0, 15, 1, 1, "R3 load15");
    cyc(1, 0, 1, 0, 1, 1, "R2 P low carry high");
    cyc(1, 1, 0, 0, 1, 1, "R2 T low carry low");
    cyc(1, 1, 1, 0, 1, 1, "R1 wrap");
    // R3: load overrides enables
    cyc(0, 1, 1, 5, 1, 1, "R3 load over count");
    // Clears override load
    cyc(0, 1, 1, 9, 1, 0, "R6 sync clear over load");
    cyc(0, 1, 1, 9, 0, 1, "R5 async clear over load");
    cyc(0, 0, 0, 7, 1, 1, "R3 load7");
    // R7: mode inputs between edges have no effect
    @(negedge clk);
    load_n = 1'b0; din = 4'd3; en_p = 1'b1; en_t = 1'b1;
    #1;
    chk("R7 qa between edges", 32'(qa), 32'(ma));
    chk("R7 qs between edges", 32'(qs), 32'(ms));
    load_n = 1'b1; en_p = 1'b0; en_t = 1'b0;
    @(posedge clk); #1;
    chk("R7 qa after edge", 32'(qa), 32'(ma));
    chk("R7 qs after edge", 32'(qs), 32'(ms));
    // R5/R6: clear dropped mid-cycle
    @(negedge clk); #2;
    ca_n = 1'b0; cs_n = 1'b0;
    #1;
    chk("R5 async clear mid-cycle", 32'(qa), 32'd0);
    chk("R6 sync clear waits for edge", 32'(qs), 32'(ms));
    ma = 0; ms = 0;
    @(posedge clk); #1;
    chk("R5 async clear held", 32'(qa), 32'd0);
    chk("R6 sync clear at edge", 32'(qs), 32'd0);
    // Near-exhaustive sweep of control and data patterns
    for (int i = 0; i < 768; i++)
      cyc((i % 7) != 3, (i % 5) != 4, (i % 3) != 1, (i * 7 + 3) % 16,
          (i % 41) != 40, (i % 43) != 42, "R1 R3 R4 sweep");
    // R8: modulus-10 by sync clear feedback
    @(negedge clk);
    chk("R8 start at zero", 32'(qm), 32'd0);
    mod_go = 1'b1;
    mm = 0;
    for (int k = 0; k < 25; k++) begin
      @(posedge clk); #1;
      mm = (mm == 9) ? 0 : mm + 1;
      chk("R8 mod10", 32'(qm), 32'(mm));
    end
    // R9: cascade against a 12-bit counter
    @(negedge clk);
    chk("R9 cascade cleared", 32'(cqv), 32'd0);
    cas_clr_n = 1'b1;
    cw = 0;
    for (int k = 0; k < 4800; k++) begin
      @(negedge clk);
      cas_p = (k % 13) != 12;
      cas_t = (k % 29) != 28;
      if (cas_p && cas_t) cw = (cw + 1) % 4096;
      @(posedge clk); #1;
      chk("R9 cascade", 32'(cqv), 32'(cw));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule